// File: doc/BRIEF.md
# I2C Bit Timing Controller

This block carries out one bit-level bus operation at a time for an I2C master: a START condition, a STOP condition, the transmission of one data bit, or the reception of one data bit. A byte sequencer above it issues a command with a one-cycle request. The block then walks the bit through four timed slices, labelled A to D, and returns to its idle slice. Each slice lasts one prescaler period: divisor + 1 clock cycles, with a 16-bit divisor.

Both bus wires are open-drain. For each wire the block presents a constant low output value and an active-low output enable, and it reads the real wire level back through a pad input. While a slave holds the clock wire low after the block has released it, the slice counter freezes. The block also tracks whether the shared bus is busy from START and STOP conditions seen on the wires. When a wire that the block has released is found low while the clock is high, it raises a sticky mismatch flag.

Top module: `i2c_bitphy`

## Requirements
- R1: After a synchronous reset, both output enables are high (both lines released), `cmd_ack` is 0, `bus_busy` is 0 and `arb_lost` is 0.
- R2: For command code 0 (START), SCL is released in A, B and C and driven low in D; SDA is released in A and B and driven low in C and D.
- R3: For command code 1 (STOP), SCL is driven low in A and released in B, C and D; SDA is driven low in A, B and C and released in D.
- R4: For command code 2 (WRITE), SDA carries `cmd_wbit` in all four slices (1 means released); SCL is low in A and D and released in B and C, so SDA changes only while SCL is low.
- R5: For command code 3 (READ), SDA stays released. The SDA pad level is sampled in the last cycle of slice B and is presented on `rd_bit` no later than the `cmd_ack` cycle.
- R6: A command request seen in the idle slice is accepted at that clock edge. Each slice then lasts `divisor`+1 cycles, so `cmd_ack` rises 4×(`divisor`+1) cycles after the accepting edge. This includes `divisor` = 0.
- R7: While the block releases SCL and the SCL pad reads low, the slice counter holds its value. A stretch of S cycles inside slice B delays `cmd_ack` by exactly S cycles.
- R8: `cmd_ack` is high for exactly one cycle: the first idle cycle after slice D. A request held high across that cycle is accepted in it, so acks of back-to-back commands are 4×(`divisor`+1)+1 cycles apart.
- R9: In idle, both lines keep the levels of the last slice D executed.
- R10: A request that arrives while a command is executing is ignored. It does not change the running command, and it produces no extra ack.
- R11: `bus_busy` rises after SDA falls while SCL stays high, and it clears after SDA rises while SCL stays high, whoever drives the wires.
- R12: `arb_lost` is set when, during a non-READ command, SDA is released by the block but reads low while SCL reads high. It stays set until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Slice length minus one, in clock cycles |
| cmd_valid | input | 1 | Command request, honoured only in idle |
| cmd | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wbit | input | 1 | Data bit for WRITE |
| cmd_ack | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Bit sampled by the last READ |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| arb_lost | output | 1 | Sticky SDA mismatch flag |
| scl_i | input | 1 | SCL pad level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe_n | output | 1 | SCL output enable, active low |
| sda_i | input | 1 | SDA pad level |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_oe_n | output | 1 | SDA output enable, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the completion ack and the acceptance of the next command. The bench provokes it by holding the request high across several commands, and it judges the result by the ack spacing and by a per-cycle behavioural model of both lines. The second pair is a clock stretch and the slice counter reaching its final count. The bench holds the SCL pad low across the end of slice B. The model and a duration check then expect the ack to be delayed by exactly the number of stretched cycles, and a request injected mid-command must leave the line pattern and the ack count unchanged.

// File: rtl/i2c_bitphy_pkg.sv
package i2c_bitphy_pkg;

    localparam int DIV_W_DEF = 16;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bit_cmd_e;

    typedef enum logic [1:0] {
        SL_A = 2'd0,
        SL_B = 2'd1,
        SL_C = 2'd2,
        SL_D = 2'd3
    } slice_e;

    // 1 = line released (pulled high), 0 = line driven low
    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
    } line_t;

    localparam line_t LINES_FREE = '{scl_rel: 1'b1, sda_rel: 1'b1};

    function automatic line_t slice_lines(bit_cmd_e c, slice_e s, logic wbit);
        line_t l;
        l = LINES_FREE;
        unique case (c)
            BC_START: begin
                l.scl_rel = (s != SL_D);
                l.sda_rel = (s == SL_A) || (s == SL_B);
            end
            BC_STOP: begin
                l.scl_rel = (s != SL_A);
                l.sda_rel = (s == SL_D);
            end
            BC_WRITE: begin
                l.scl_rel = (s == SL_B) || (s == SL_C);
                l.sda_rel = wbit;
            end
            BC_READ: begin
                l.scl_rel = (s == SL_B) || (s == SL_C);
                l.sda_rel = 1'b1;
            end
            default: l = LINES_FREE;
        endcase
        return l;
    endfunction

    function automatic slice_e next_slice(slice_e s);
        return slice_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/i2c_bit_prescale.sv
module i2c_bit_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             zero
);
    localparam logic [DIV_W-1:0] CNT_ZERO = '0;

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_ZERO;
        end else if (load) begin
            cnt <= divisor;
        end else if (run && (cnt != CNT_ZERO)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == CNT_ZERO);

    // R6: the counter is reloaded before it could wrap below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |-> (cnt != CNT_ZERO));

    // R7: an idle (frozen) counter keeps its value
    a_r7_frozen_count: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
    import i2c_bitphy_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  bit_cmd_e cmd,
    input  logic     cmd_wbit,
    input  logic     cnt_zero,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     active,
    output logic     accept,
    output logic     step,
    output logic     stall,
    output line_t    lines,
    output logic     cmd_ack,
    output logic     rd_bit,
    output logic     arb_lost
);
    slice_e   ph;
    bit_cmd_e cmd_q;
    logic     wbit_q;
    line_t    hold_q;

    always_comb begin
        lines  = active ? slice_lines(cmd_q, ph, wbit_q) : hold_q;
        stall  = active && lines.scl_rel && !scl_i;
        accept = !active && cmd_valid;
        step   = active && !stall && cnt_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            ph       <= SL_A;
            cmd_q    <= BC_START;
            wbit_q   <= 1'b0;
            hold_q   <= LINES_FREE;
            cmd_ack  <= 1'b0;
            rd_bit   <= 1'b0;
            arb_lost <= 1'b0;
        end else begin
            cmd_ack <= 1'b0;
            if (accept) begin
                active   <= 1'b1;
                ph       <= SL_A;
                cmd_q    <= cmd;
                wbit_q   <= cmd_wbit;
                arb_lost <= 1'b0;
            end else if (step) begin
                if (ph == SL_D) begin
                    active  <= 1'b0;
                    hold_q  <= lines;
                    cmd_ack <= 1'b1;
                end else begin
                    ph <= next_slice(ph);
                end
                if ((ph == SL_B) && (cmd_q == BC_READ)) begin
                    rd_bit <= sda_i;
                end
            end
            if (active && lines.sda_rel && (cmd_q != BC_READ) && scl_i && !sda_i) begin
                arb_lost <= 1'b1;
            end
        end
    end

    // R8: completion pulse never lasts two cycles
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> !cmd_ack);

    // R7: a stretched clock freezes the slice
    a_r7_stretch_holds_slice: assert property (@(posedge clk) disable iff (rst)
        (active && lines.scl_rel && !scl_i) |=> (active && $stable(ph)));

    // R4: during data bits SDA moves only while SCL is driven low
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (active && ((cmd_q == BC_WRITE) || (cmd_q == BC_READ)) && !$stable(lines.sda_rel))
        |-> !lines.scl_rel);

    // R10: a running command is not replaced by a new request
    a_r10_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(cmd_q));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    logic scl_q;
    logic sda_q;
    logic start_seen;
    logic stop_seen;

    always_comb begin
        start_seen = scl_i && scl_q && sda_q && !sda_i;
        stop_seen  = scl_i && scl_q && !sda_q && sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (start_seen) begin
                busy <= 1'b1;
            end else if (stop_seen) begin
                busy <= 1'b0;
            end
        end
    end

    // R11: busy only rises after SDA was seen low with SCL high
    a_r11_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(scl_i && !sda_i));

    // R11: busy only clears after SDA was seen high with SCL high
    a_r11_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(scl_i && sda_i));

endmodule

// File: rtl/i2c_bitphy.sv
module i2c_bitphy
    import i2c_bitphy_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  logic             cmd_wbit,
    output logic             cmd_ack,
    output logic             rd_bit,
    output logic             bus_busy,
    output logic             arb_lost,
    input  logic             scl_i,
    output logic             scl_o,
    output logic             scl_oe_n,
    input  logic             sda_i,
    output logic             sda_o,
    output logic             sda_oe_n
);
    logic  active;
    logic  accept;
    logic  step;
    logic  stall;
    logic  cnt_zero;
    line_t lines;

    i2c_bit_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd      (bit_cmd_e'(cmd)),
        .cmd_wbit (cmd_wbit),
        .cnt_zero (cnt_zero),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .active   (active),
        .accept   (accept),
        .step     (step),
        .stall    (stall),
        .lines    (lines),
        .cmd_ack  (cmd_ack),
        .rd_bit   (rd_bit),
        .arb_lost (arb_lost)
    );

    i2c_bit_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .load   (accept || step),
        .run    (active && !stall),
        .divisor(divisor),
        .zero   (cnt_zero)
    );

    i2c_bus_watch u_watch (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .busy (bus_busy)
    );

    assign scl_o    = 1'b0;
    assign sda_o    = 1'b0;
    assign scl_oe_n = lines.scl_rel;
    assign sda_oe_n = lines.sda_rel;

    // R1: the open-drain outputs never drive a high level
    a_r1_open_drain: assert property (@(posedge clk) disable iff (rst)
        (!scl_o && !sda_o));

endmodule

// File: tb/i2c_bitphy_bench.sv
module i2c_bitphy_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] divisor = 16'd3;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        cmd_wbit = 1'b0;
    logic        stretch = 1'b0;
    logic        slave_sda = 1'b0;
    logic        cmd_ack, rd_bit, bus_busy, arb_lost;
    logic        scl_o, scl_oe_n, sda_o, sda_oe_n;
    wire         scl_line;
    wire         sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit started  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = (scl_oe_n ? 1'b1 : scl_o) & ~stretch;
    assign sda_line = (sda_oe_n ? 1'b1 : sda_o) & ~slave_sda;

    i2c_bitphy u_i2c_bitphy (
        .clk(clk), .rst(rst), .divisor(divisor),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_wbit(cmd_wbit),
        .cmd_ack(cmd_ack), .rd_bit(rd_bit), .bus_busy(bus_busy), .arb_lost(arb_lost),
        .scl_i(scl_line), .scl_o(scl_o), .scl_oe_n(scl_oe_n),
        .sda_i(sda_line), .sda_o(sda_o), .sda_oe_n(sda_oe_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph;        // -1 = idle, 0..3 = slices A..D
    int m_cnt;
    int m_cmd;
    bit m_wbit, m_hscl, m_hsda, m_ack, m_rd, m_busy, m_sclq, m_sdaq, m_arb;

    function automatic bit want_scl(int ph, int c, bit h);
        if (ph < 0) return h;
        if (c == 0) return ph != 3;
        if (c == 1) return ph != 0;
        return (ph == 1) || (ph == 2);
    endfunction

    function automatic bit want_sda(int ph, int c, bit w, bit h);
        if (ph < 0) return h;
        if (c == 0) return ph < 2;
        if (c == 1) return ph == 3;
        if (c == 2) return w;
        return 1'b1;
    endfunction

    function automatic string line_req(int ph, int c);
        if (ph < 0) return "R9";
        if (c == 0) return "R2";
        if (c == 1) return "R3";
        if (c == 2) return "R4";
        return "R5";
    endfunction

    always @(posedge clk) begin
        bit ps, pd, ls, ld, st;
        started <= 1'b1;
        cyc++;
        if (rst) begin
            m_ph = -1; m_cnt = 0; m_cmd = 0; m_wbit = 0;
            m_hscl = 1; m_hsda = 1; m_ack = 0; m_rd = 0;
            m_busy = 0; m_sclq = 1; m_sdaq = 1; m_arb = 0;
        end else begin
            ps = want_scl(m_ph, m_cmd, m_hscl);
            pd = want_sda(m_ph, m_cmd, m_wbit, m_hsda);
            ls = ps & ~stretch;
            ld = pd & ~slave_sda;
            st = (m_ph >= 0) && ps && !ls;
            if ((m_ph >= 0) && pd && (m_cmd != 3) && ls && !ld) m_arb = 1;
            if (ls && m_sclq && m_sdaq && !ld) m_busy = 1;
            else if (ls && m_sclq && !m_sdaq && ld) m_busy = 0;
            m_sclq = ls;
            m_sdaq = ld;
            m_ack = 0;
            if (m_ph < 0) begin
                if (cmd_valid) begin
                    m_ph = 0; m_cnt = divisor; m_cmd = cmd; m_wbit = cmd_wbit; m_arb = 0;
                end
            end else if (!st) begin
                if (m_cnt == 0) begin
                    if (m_ph == 1 && m_cmd == 3) m_rd = ld;
                    if (m_ph == 3) begin
                        m_ph = -1; m_hscl = ps; m_hsda = pd; m_ack = 1;
                    end else begin
                        m_ph = m_ph + 1;
                    end
                    m_cnt = divisor;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(line_req(m_ph, m_cmd), "scl_oe_n", scl_oe_n, want_scl(m_ph, m_cmd, m_hscl));
            chk(line_req(m_ph, m_cmd), "sda_oe_n", sda_oe_n, want_sda(m_ph, m_cmd, m_wbit, m_hsda));
            chk("R8", "cmd_ack", cmd_ack, m_ack);
            chk("R5", "rd_bit", rd_bit, m_rd);
            chk("R11", "bus_busy", bus_busy, m_busy);
            chk("R12", "arb_lost", arb_lost, m_arb);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic run_cmd(input logic [1:0] c, input logic wb, input int rel_at,
                           input int spur_at, output int dur, output int acks);
        int k;
        @(posedge clk); #2;
        cmd = c; cmd_wbit = wb; cmd_valid = 1'b1;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
        k = 0; dur = -1; acks = 0;
        while (k < 2000) begin
            @(negedge clk);
            if (rel_at >= 0 && k == rel_at) stretch = 1'b0;
            if (spur_at >= 0 && k == spur_at) begin cmd_valid = 1'b1; cmd = 2'd1; end
            if (spur_at >= 0 && k == spur_at + 3) cmd_valid = 1'b0;
            if (cmd_ack) begin
                acks++;
                if (dur < 0) dur = k;
            end
            if (dur >= 0 && k >= dur + 5) break;
            k++;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int dur, acks;
        int t[3];
        int na;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "scl_oe_n", scl_oe_n, 1);
        chk("R1", "sda_oe_n", sda_oe_n, 1);
        chk("R1", "cmd_ack", cmd_ack, 0);
        chk("R1", "bus_busy", bus_busy, 0);
        chk("R1", "arb_lost", arb_lost, 0);

        // R11 foreign START/STOP on an idle bus
        wait_cycles(1);
        slave_sda = 1'b1;
        wait_cycles(3);
        chk("R11", "busy after foreign start", bus_busy, 1);
        slave_sda = 1'b0;
        wait_cycles(3);
        chk("R11", "busy after foreign stop", bus_busy, 0);

        // R2 / R6 START with divisor 3
        divisor = 16'd3;
        run_cmd(2'd0, 1'b0, -1, -1, dur, acks);
        chk("R6", "START duration", dur, 16);
        chk("R11", "busy after own start", bus_busy, 1);
        wait_cycles(4);
        chk("R9", "idle scl held low", scl_oe_n, 0);
        chk("R9", "idle sda held low", sda_oe_n, 0);

        // R4 data bits
        run_cmd(2'd2, 1'b1, -1, -1, dur, acks);
        chk("R4", "WRITE1 duration", dur, 16);
        run_cmd(2'd2, 1'b0, -1, -1, dur, acks);
        chk("R4", "WRITE0 duration", dur, 16);

        // R5 reads
        slave_sda = 1'b1;
        run_cmd(2'd3, 1'b0, -1, -1, dur, acks);
        chk("R5", "read low bit", rd_bit, 0);
        slave_sda = 1'b0;
        run_cmd(2'd3, 1'b0, -1, -1, dur, acks);
        chk("R5", "read high bit", rd_bit, 1);

        // R7 clock stretch of 7 cycles in slice B (release at k = 4 + 7)
        stretch = 1'b1;
        run_cmd(2'd2, 1'b0, 11, -1, dur, acks);
        chk("R7", "stretched WRITE duration", dur, 23);

        // R6 boundary: divisor 0
        divisor = 16'd0;
        run_cmd(2'd2, 1'b1, -1, -1, dur, acks);
        chk("R6", "divisor0 duration", dur, 4);

        // R10 request during execution is ignored
        divisor = 16'd3;
        run_cmd(2'd2, 1'b0, -1, 2, dur, acks);
        chk("R10", "duration with stray request", dur, 16);
        chk("R10", "ack count with stray request", acks, 1);

        // R8 back-to-back commands accepted in the ack cycle
        divisor = 16'd1;
        @(posedge clk); #2;
        cmd = 2'd2; cmd_wbit = 1'b0; cmd_valid = 1'b1;
        na = 0;
        while (na < 3) begin
            @(negedge clk);
            if (cmd_ack) begin
                t[na] = cyc;
                na++;
                if (na == 3) cmd_valid = 1'b0;
            end
        end
        chk("R8", "ack spacing 1-2", t[1] - t[0], 9);
        chk("R8", "ack spacing 2-3", t[2] - t[1], 9);
        wait_cycles(2);
        chk("R8", "ack low after pulse", cmd_ack, 0);

        // R12 mismatch while sending a released bit
        divisor = 16'd3;
        slave_sda = 1'b1;
        run_cmd(2'd2, 1'b1, -1, -1, dur, acks);
        chk("R12", "arb_lost set", arb_lost, 1);
        slave_sda = 1'b0;
        wait_cycles(1);
        chk("R12", "arb_lost sticky", arb_lost, 1);

        // R3 STOP clears flag and bus busy
        run_cmd(2'd1, 1'b0, -1, -1, dur, acks);
        chk("R3", "STOP duration", dur, 16);
        chk("R12", "arb_lost cleared by new command", arb_lost, 0);
        chk("R11", "busy after own stop", bus_busy, 0);
        wait_cycles(2);
        chk("R3", "lines released after STOP", {31'd0, scl_oe_n & sda_oe_n}, 1);

        report();
    end

endmodule